// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each destination MAC address taken from a received frame, whether that frame is kept or dropped. The address arrives already extracted, as a 48-bit word with a one-cycle valid strobe. The block feeds the address, one byte per cycle, through a bit-reflected CRC-32. It then uses the nine most significant bits of the remainder to select one bit of a 512-bit group-address table.

Software sets and clears table bits one at a time. Each 32-bit configuration write carries an entry index and the value to store at that index. A promiscuous input, the programmed station address and a fixed broadcast bypass are merged with the table result into a single accept/reject answer. The answer is returned with a done strobe.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset every table entry is clear, `busy` and `result_valid` are low, and a group address that is not broadcast is rejected.
- R2: A cycle with `cfg_wr_en` high stores `cfg_wr_data[9]` into the table entry selected by `cfg_wr_data[8:0]`. The value 1 enables the entry and 0 disables it. No other entry changes.
- R3: The table index is bits [31:23] of a CRC-32 register. The register starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, shifts LSB first and has no final inversion. It is run over the address bytes `dest_addr[7:0]` first through `dest_addr[47:40]` last.
- R4: A group address has `dest_addr[0]` = 1 and is not all ones. With promiscuous mode off, such an address is accepted exactly when its table entry is set.
- R5: An individual address has `dest_addr[0]` = 0. With promiscuous mode off, it is accepted exactly when it equals `{station_hi, station_lo}`, where `station_lo[7:0]` holds the first byte. The table is never consulted for such an address.
- R6: While `promisc_en` is high, every address is accepted.
- R7: The all-ones broadcast address is accepted even when its table entry is clear.
- R8: An address is taken when `addr_valid` is high and `busy` is low. `busy` is then high for 7 cycles, and `result_valid` pulses for one cycle on the edge where `busy` falls. So the result appears 7 clock edges after the address is taken.
- R9: `addr_valid` while `busy` is high is ignored and produces no extra result.
- R10: `result_accept` is low in every cycle where `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Table control write strobe |
| cfg_wr_data | input | 32 | [8:0] entry index, [9] value to store |
| promisc_en | input | 1 | Accept every address |
| station_lo | input | 32 | Station address bytes 0 to 3, byte 0 in [7:0] |
| station_hi | input | 16 | Station address bytes 4 and 5 |
| addr_valid | input | 1 | Destination address strobe |
| dest_addr | input | 48 | Destination address, first byte in [7:0] |
| busy | output | 1 | Lookup in progress, new addresses ignored |
| result_valid | output | 1 | One-cycle done strobe |
| result_accept | output | 1 | Accept decision, qualified by result_valid |

## Verification
The hardest case to reach from the ports is a set table entry selected through the CRC. A random group address almost never lands on the one entry software has set. The bench therefore computes the index of a chosen address with its own serial CRC, programs exactly that entry, and then looks up both that address and a neighbour whose index differs. It also programs the index of an individual address to show that the table is not consulted for it. It drives addresses into the busy window to show they are dropped.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam int unsigned CRC_W    = 32;
   localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
   localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_HASH   = 2'd1,
      ST_DECIDE = 2'd2
   } lookup_state_e;

   // Advance a reflected CRC by one byte, least significant bit first.
   function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] cur,
                                                    input logic [7:0]       data);
      logic [CRC_W-1:0] r;
      r = cur;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ data[i]) r = (r >> 1) ^ CRC_POLY;
         else                r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
   import mhf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc
);

   logic [CRC_W-1:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= CRC_INIT;
      else if (load)  crc_q <= CRC_INIT;
      else if (step)  crc_q <= crc_advance(crc_q, din);
   end

   assign crc = crc_q;

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int unsigned ENTRIES = 512,
   parameter int unsigned WORD_W  = 32,
   localparam int unsigned IDX_W     = $clog2(ENTRIES),
   localparam int unsigned NUM_WORDS = ENTRIES / WORD_W,
   localparam int unsigned BSEL_W    = $clog2(WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);

   if (ENTRIES % WORD_W != 0 || (1 << IDX_W) != ENTRIES || NUM_WORDS < 2) begin : g_bad_geom
      $error("mhf_hash_table: ENTRIES must be a power of two and a multiple of WORD_W");
   end

   logic [ENTRIES-1:0] flat;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              hit;
      assign hit = wr_en && (wr_idx[IDX_W-1:BSEL_W] == (IDX_W-BSEL_W)'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q <= '0;
         else if (hit) word_q[wr_idx[BSEL_W-1:0]] <= wr_val;
      end
      assign flat[w*WORD_W +: WORD_W] = word_q;
   end

   assign rd_bit = flat[rd_idx];

endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
   parameter int unsigned ADDR_W       = 48,
   parameter bit          BCAST_BYPASS = 1'b1
) (
   input  logic              promisc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] station,
   input  logic              table_hit,
   output logic              accept
);

   logic is_group;
   logic station_hit;
   logic bcast_ok;

   assign is_group    = addr[0];
   assign station_hit = (addr == station);

   if (BCAST_BYPASS) begin : g_bcast_on
      assign bcast_ok = &addr;
   end else begin : g_bcast_off
      assign bcast_ok = 1'b0;
   end

   assign accept = promisc | bcast_ok | (is_group ? table_hit : station_hit);

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int unsigned ENTRIES      = 512,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned CFG_W        = 32,
   parameter int unsigned ADDR_BYTES   = 6,
   parameter bit          BCAST_BYPASS = 1'b1,
   localparam int unsigned ADDR_W  = 8 * ADDR_BYTES,
   localparam int unsigned IDX_W   = $clog2(ENTRIES),
   localparam int unsigned HI_W    = ADDR_W - 32,
   localparam int unsigned CNT_W   = $clog2(ADDR_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CFG_W-1:0]  cfg_wr_data,
   input  logic              promisc_en,
   input  logic [31:0]       station_lo,
   input  logic [HI_W-1:0]   station_hi,
   input  logic              addr_valid,
   input  logic [ADDR_W-1:0] dest_addr,
   output logic              busy,
   output logic              result_valid,
   output logic              result_accept
);

   if (ADDR_BYTES <= 4 || ADDR_BYTES < 2) begin : g_bad_addr
      $error("mcast_hash_filter: ADDR_BYTES must exceed 4");
   end
   if (IDX_W + 1 > CFG_W || IDX_W > CRC_W) begin : g_bad_cfg
      $error("mcast_hash_filter: index plus value bit must fit the control word and the CRC");
   end

   lookup_state_e     state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] shift_q;
   logic [CRC_W-1:0]  crc;
   logic              take;
   logic              table_hit;
   logic              accept_c;
   logic              unused_cfg;

   assign take = (state_q == ST_IDLE) && addr_valid;
   assign busy = (state_q != ST_IDLE);
   assign unused_cfg = ^cfg_wr_data[CFG_W-1:IDX_W+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         cnt_q         <= '0;
         addr_q        <= '0;
         shift_q       <= '0;
         result_valid  <= 1'b0;
         result_accept <= 1'b0;
      end else begin
         result_valid  <= 1'b0;
         result_accept <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (addr_valid) begin
                  addr_q  <= dest_addr;
                  shift_q <= dest_addr;
                  cnt_q   <= '0;
                  state_q <= ST_HASH;
               end
            end
            ST_HASH: begin
               shift_q <= shift_q >> 8;
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(ADDR_BYTES - 1)) state_q <= ST_DECIDE;
            end
            ST_DECIDE: begin
               result_valid  <= 1'b1;
               result_accept <= accept_c;
               state_q       <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   mhf_crc_unit u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take),
      .step  (state_q == ST_HASH),
      .din   (shift_q[7:0]),
      .crc   (crc)
   );

   mhf_hash_table #(
      .ENTRIES (ENTRIES),
      .WORD_W  (WORD_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_idx (cfg_wr_data[IDX_W-1:0]),
      .wr_val (cfg_wr_data[IDX_W]),
      .rd_idx (crc[CRC_W-1 -: IDX_W]),
      .rd_bit (table_hit)
   );

   mhf_decide #(
      .ADDR_W       (ADDR_W),
      .BCAST_BYPASS (BCAST_BYPASS)
   ) u_decide (
      .promisc   (promisc_en),
      .addr      (addr_q),
      .station   ({station_hi, station_lo}),
      .table_hit (table_hit),
      .accept    (accept_c)
   );

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int unsigned ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic              busy,
   input logic              result_valid,
   input logic              result_accept,
   input logic              promisc_en,
   input logic [31:0]       station_lo,
   input logic [ADDR_W-33:0] station_hi,
   input logic [ADDR_W-1:0] addr_q
);

   a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && addr_valid) |=> busy);

   a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> result_valid);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));

   a_r10_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> !result_accept);

   a_r6_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && $past(promisc_en)) |-> result_accept);

   a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && (&$past(addr_q))) |-> result_accept);

   a_r5_station: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !$past(promisc_en) && !$past(addr_q[0]))
         |-> (result_accept == ($past(addr_q) == {$past(station_hi), $past(station_lo)})));

endmodule

bind mcast_hash_filter mhf_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .addr_valid    (addr_valid),
   .busy          (busy),
   .result_valid  (result_valid),
   .result_accept (result_accept),
   .promisc_en    (promisc_en),
   .station_lo    (station_lo),
   .station_hi    (station_hi),
   .addr_q        (addr_q)
);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic        promisc_en = 1'b0;
   logic [31:0] station_lo = '0;
   logic [15:0] station_hi = '0;
   logic        addr_valid = 1'b0;
   logic [47:0] dest_addr = '0;
   logic        busy, result_valid, result_accept;

   always #2 clk = ~clk;

   mcast_hash_filter u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data),
      .promisc_en (promisc_en), .station_lo (station_lo), .station_hi (station_hi),
      .addr_valid (addr_valid), .dest_addr (dest_addr),
      .busy (busy), .result_valid (result_valid), .result_accept (result_accept)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] ref_hash(input logic [47:0] a);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < 48; i++) begin
         if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
         else             c = c >> 1;
      end
      return c[31:23];
   endfunction

   // Behavioural reference model, advanced on every rising edge.
   bit    ref_tbl [512];
   int    rem = 0;
   bit    exp_valid = 0, exp_acc = 0, pend_acc = 0;
   string pend_tag = "R1", out_tag = "R1";
   int    pulses = 0;

   function automatic bit ref_accept(input logic [47:0] a);
      if (promisc_en) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[0]) return ref_tbl[ref_hash(a)];
      return a == {station_hi, station_lo};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         rem = 0; exp_valid = 0; exp_acc = 0;
         foreach (ref_tbl[i]) ref_tbl[i] = 1'b0;
      end else begin
         exp_valid = 0; exp_acc = 0;
         if (rem > 0) begin
            rem--;
            if (rem == 0) begin
               exp_valid = 1; exp_acc = pend_acc; out_tag = pend_tag;
            end
         end else if (addr_valid) begin
            rem = 7; pend_acc = ref_accept(dest_addr); pend_tag = cur_tag;
         end
         if (cfg_wr_en) ref_tbl[cfg_wr_data[8:0]] = cfg_wr_data[9];
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         if (result_valid) pulses++;
         chk("R8 busy", busy, rem > 0);
         chk("R8 result_valid", result_valid, exp_valid);
         if (exp_valid) chk(out_tag, result_accept, exp_acc);
         else           chk("R10 accept idle", result_accept, 0);
      end
   end

   task automatic wr_cfg(input logic [8:0] idx, input bit val);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = {22'h2A5A5A, val, idx};
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_wr_data = '0;
   endtask

   task automatic lookup(input logic [47:0] a, input string tag);
      @(negedge clk);
      cur_tag = tag; dest_addr = a; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [47:0] m1, m2, uc, a;
      logic [47:0] stn;
      int p0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      chk("R1 valid in reset", result_valid, 0);
      rst_n = 1'b1;

      m1 = 48'h2301_5E00_0001 | 48'h1;
      m1 = 48'h0100_5E00_0001;   // group address, bit 0 of first byte set
      m1 = {m1[47:8], 8'h01};
      lookup(m1, "R1 empty table");

      stn = 48'h0A0B_0C0D_0E02;
      station_lo = stn[31:0]; station_hi = stn[47:32];
      lookup(stn, "R5 station match");
      lookup(stn ^ 48'h0000_0001_0000, "R5 station mismatch");

      wr_cfg(ref_hash(m1), 1'b1);
      lookup(m1, "R3 programmed index");
      m2 = m1;
      for (int k = 1; k < 64 && ref_hash(m2) == ref_hash(m1); k++) m2 = m1 ^ (48'(k) << 8);
      lookup(m2, "R2 neighbour untouched");
      wr_cfg(ref_hash(m1), 1'b0);
      lookup(m1, "R2 entry cleared");

      lookup(48'hFFFF_FFFF_FFFF, "R7 broadcast");

      uc = 48'h1122_3344_5566;
      wr_cfg(ref_hash(uc), 1'b1);
      lookup(uc, "R5 table ignored for individual");
      wr_cfg(ref_hash(uc), 1'b0);

      promisc_en = 1'b1;
      lookup(uc, "R6 promisc individual");
      lookup(m2, "R6 promisc group");
      promisc_en = 1'b0;

      p0 = pulses;
      @(negedge clk);
      cur_tag = "R9 first lookup"; dest_addr = m2; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
      @(negedge clk);
      cur_tag = "R9 dropped"; dest_addr = 48'hFFFF_FFFF_FFFF; addr_valid = 1'b1;
      repeat (3) @(negedge clk);
      addr_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 result count", pulses - p0, 1);

      for (int i = 0; i < 8; i++) begin
         a = {$urandom(), $urandom()};
         a[0] = 1'b1;
         wr_cfg(ref_hash(a), 1'b1);
         lookup(a, "R4 group hit");
         lookup(a ^ 48'h0000_0000_1200, "R4 group other");
      end

      p0 = pulses;
      @(negedge clk);
      cur_tag = "R8 back to back"; dest_addr = stn; addr_valid = 1'b1;
      repeat (24) @(negedge clk);
      addr_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk("R8 back to back count", pulses - p0, 3);

      finish_run();
   end

endmodule